// File: doc/BRIEF.md
# Decimal-Capable Add-With-Carry Accumulator

This block is the add-with-carry datapath of a small 8-bit processor. It keeps an 8-bit accumulator and four status flags: carry, zero, negative and overflow. An operand arrives on a valid/ready input. Once it is accepted, the block adds the operand and the current carry flag to the accumulator. On the following clock edge it writes back the accumulator and all four flags. A decimal-mode input is captured with the operand. It selects plain binary addition or packed two-digit BCD addition with decimal correction.

In decimal mode the flags are set the way an early 8-bit processor sets them. The zero flag comes from the uncorrected binary sum. The negative and overflow flags come from the sum after only the low-digit correction. Only the carry flag reflects the full decimal result. Operands that are not valid BCD digits follow the same arithmetic and raise no error.

A separate load strobe presets the accumulator and the flags, for example to set up a carry-in. Back-pressure works as follows:
- `op_ready` is low for exactly one cycle after each acceptance, while the add is in flight.
- `op_ready` is also low in any cycle where `ld_en` is high, because a load takes priority over a new operand.
- A producer must hold `op_data` and `dec_mode` stable while `op_valid` is high and `op_ready` is low.

Top module: `bcd_acc_adder`

## Requirements
- R1: After a synchronous reset the accumulator, all four flags and `done` are 0, and `op_ready` is 1 while `ld_en` is 0.
- R2: An operand is accepted on a rising edge where `op_valid` and `op_ready` are both 1. In the following cycle `op_ready` is 0, and `op_valid` has no effect in that cycle.
- R3: The accumulator and flags take the new result on the edge after acceptance, and `done` is 1 for exactly that one cycle. Otherwise the accumulator and flags hold unless a load occurs.
- R4: In binary mode (`dec_mode`=0) the accumulator becomes the low 8 bits of acc+operand+C. C is set when that sum exceeds 255, and N equals bit 7 of the sum.
- R5: In both modes Z is set exactly when the low 8 bits of the uncorrected binary sum acc+operand+C are zero.
- R6: In decimal mode, 6 is added to the sum when the low nibble of acc plus the low nibble of the operand plus C exceeds 9.
- R7: In decimal mode N is bit 7 of the sum after the low-digit correction, taken before any high-digit correction.
- R8: In decimal mode, when the low-corrected sum exceeds 0x99, 0x60 is added and C is set; otherwise C is cleared. The accumulator takes the low 8 bits. Valid BCD inputs always give a valid BCD accumulator.
- R9: V is set when acc and operand share bit 7 and the sum's bit 7 differs from acc bit 7. The sum is the binary sum in binary mode and the low-corrected sum in decimal mode.
- R10: With `ld_en`=1 and no add in flight, the next edge loads `ld_acc` into the accumulator and `ld_flags` into the flags. The flag bits are [3]=N, [2]=V, [1]=Z, [0]=C. While an add is in flight, `ld_en` is ignored.
- R11: In decimal mode, nibbles above 9 are processed by the same rules, with no error indication.
- R12: The carry-in of every add is the carry flag held at the moment the add executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operand offered |
| op_ready | output | 1 | Operand can be accepted this cycle |
| op_data | input | 8 | Operand value |
| dec_mode | input | 1 | 1 selects BCD arithmetic, captured with the operand |
| ld_en | input | 1 | Preset strobe |
| ld_acc | input | 8 | Accumulator preset value |
| ld_flags | input | 4 | Flag preset {N,V,Z,C} |
| acc | output | 8 | Accumulator |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| done | output | 1 | One-cycle pulse when a result is written |

## Verification
The embedded assertions check the handshake timing on every cycle:
- `op_ready` falls after each acceptance.
- `done` follows an acceptance and lasts one cycle.
- The accumulator holds while idle.

They also check two arithmetic invariants: binary-mode Z agrees with a zero accumulator, and decimal adds of valid BCD inputs produce BCD digits.

The exact flag quirks of decimal mode can only be shown by the bench's reference model and its scenarios. These are Z taken from the uncorrected sum, N and V taken from the half-corrected sum, and the handling of non-BCD nibbles. The same applies to the carry-in chaining and to load priority.

// File: rtl/bcd_acc_pkg.sv
package bcd_acc_pkg;
  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } acc_flags_t;
endpackage

// File: rtl/bcd_acc_arith.sv
module bcd_acc_arith
  import bcd_acc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] m_in,
  input  logic          cin,
  input  logic          dec,
  output logic [DW-1:0] res,
  output acc_flags_t    fo
);
  localparam int NW = DW / 2;
  localparam int SW = DW + 2;

  logic [SW-1:0] raw_sum, half_adj, full_adj, flag_src;
  logic [NW:0]   low_digits;
  logic          low_fix, high_fix;

  always_comb begin
    raw_sum    = SW'(a_in) + SW'(m_in) + SW'(cin);
    low_digits = (NW+1)'(a_in[NW-1:0]) + (NW+1)'(m_in[NW-1:0]) + (NW+1)'(cin);
    low_fix    = dec && (low_digits > (NW+1)'(9));
    half_adj   = low_fix ? raw_sum + SW'(6) : raw_sum;
    high_fix   = half_adj > SW'(153);
    full_adj   = high_fix ? half_adj + SW'(96) : half_adj;
    flag_src   = dec ? half_adj : raw_sum;
    fo.z       = (raw_sum[DW-1:0] == '0);
    fo.n       = flag_src[DW-1];
    fo.v       = ~(a_in[DW-1] ^ m_in[DW-1]) & (a_in[DW-1] ^ flag_src[DW-1]);
    fo.c       = dec ? high_fix : raw_sum[DW];
    res        = dec ? full_adj[DW-1:0] : raw_sum[DW-1:0];
  end
endmodule

// File: rtl/bcd_acc_ctrl.sv
module bcd_acc_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic op_valid,
  input  logic ld_en,
  output logic op_ready,
  output logic accept,
  output logic load_ok,
  output logic busy,
  output logic done
);
  logic busy_q, done_q;

  assign op_ready = !busy_q && !ld_en;
  assign accept   = op_valid && op_ready;
  assign load_ok  = ld_en && !busy_q;
  assign busy     = busy_q;
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= accept;
      done_q <= busy_q;
    end
  end

  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> !op_ready);
  assert_done_follows_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> ##1 done);
  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/bcd_acc_opreg.sv
module bcd_acc_opreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] d_in,
  input  logic          dec_in,
  output logic [DW-1:0] d_q,
  output logic          dec_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      d_q   <= '0;
      dec_q <= 1'b0;
    end else if (capture) begin
      d_q   <= d_in;
      dec_q <= dec_in;
    end
  end
endmodule

// File: rtl/bcd_acc_adder.sv
module bcd_acc_adder
  import bcd_acc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [DW-1:0] op_data,
  input  logic          dec_mode,
  input  logic          ld_en,
  input  logic [DW-1:0] ld_acc,
  input  logic [3:0]    ld_flags,
  output logic [DW-1:0] acc,
  output logic          flag_c,
  output logic          flag_z,
  output logic          flag_n,
  output logic          flag_v,
  output logic          done
);
  localparam int NW = DW / 2;

  logic          accept, load_ok, busy;
  logic [DW-1:0] op_q, sum_res, acc_q;
  logic          dec_q;
  acc_flags_t    flg_q, sum_flg;

  bcd_acc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .op_valid(op_valid), .ld_en(ld_en),
    .op_ready(op_ready), .accept(accept), .load_ok(load_ok),
    .busy(busy), .done(done)
  );

  bcd_acc_opreg #(.DW(DW)) u_opreg (
    .clk(clk), .rst(rst), .capture(accept), .d_in(op_data),
    .dec_in(dec_mode), .d_q(op_q), .dec_q(dec_q)
  );

  bcd_acc_arith #(.DW(DW)) u_arith (
    .a_in(acc_q), .m_in(op_q), .cin(flg_q.c), .dec(dec_q),
    .res(sum_res), .fo(sum_flg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      flg_q <= '0;
    end else if (busy) begin
      acc_q <= sum_res;
      flg_q <= sum_flg;
    end else if (load_ok) begin
      acc_q <= ld_acc;
      flg_q <= acc_flags_t'(ld_flags);
    end
  end

  assign acc    = acc_q;
  assign flag_c = flg_q.c;
  assign flag_z = flg_q.z;
  assign flag_n = flg_q.n;
  assign flag_v = flg_q.v;

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ld_en) |=> $stable(acc_q));
  assert_bin_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !dec_q) |-> (flag_z == (acc == '0)));
  assert_bcd_digits_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && dec_q && op_q[NW-1:0] <= NW'(9) && op_q[DW-1:NW] <= NW'(9)
          && acc_q[NW-1:0] <= NW'(9) && acc_q[DW-1:NW] <= NW'(9))
    |=> (acc_q[NW-1:0] <= NW'(9) && acc_q[DW-1:NW] <= NW'(9)));
endmodule

// File: tb/bcd_acc_adder_tb.sv
module bcd_acc_adder_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0, dec_mode = 1'b0, ld_en = 1'b0;
  logic [7:0] op_data = '0, ld_acc = '0;
  logic [3:0] ld_flags = '0;
  logic       op_ready, flag_c, flag_z, flag_n, flag_v, done;
  logic [7:0] acc;

  int errors = 0, checks = 0;
  string cur_tag = "R1";

  // behavioural reference state
  int m_acc = 0, m_op = 0;
  bit m_c, m_z, m_n, m_v, m_busy, m_done, m_dec;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_acc_adder u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_data(op_data), .dec_mode(dec_mode), .ld_en(ld_en), .ld_acc(ld_acc),
    .ld_flags(ld_flags), .acc(acc), .flag_c(flag_c), .flag_z(flag_z),
    .flag_n(flag_n), .flag_v(flag_v), .done(done)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0; m_c = 0; m_z = 0; m_n = 0; m_v = 0;
      m_busy = 0; m_done = 0; m_dec = 0; m_op = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        int s, t, ci;
        ci = m_c ? 1 : 0;
        s = m_acc + m_op + ci;
        m_z = ((s % 256) == 0);
        if (m_dec) begin
          t = s;
          if ((m_acc % 16) + (m_op % 16) + ci > 9) t = t + 6;
          m_n = ((t / 128) % 2) == 1;
          m_v = (((m_acc ^ m_op) & 128) == 0) && (((m_acc ^ t) & 128) != 0);
          if (t > 153) begin t = t + 96; m_c = 1; end else m_c = 0;
        end else begin
          t = s;
          m_n = ((t / 128) % 2) == 1;
          m_v = (((m_acc ^ m_op) & 128) == 0) && (((m_acc ^ t) & 128) != 0);
          m_c = (t > 255);
        end
        m_acc = t % 256;
        m_busy = 0;
        m_done = 1;
      end else if (ld_en) begin
        m_acc = ld_acc;
        {m_n, m_v, m_z, m_c} = ld_flags;
      end else if (op_valid) begin
        m_op = op_data;
        m_dec = dec_mode;
        m_busy = 1;
      end
    end
  end

  task automatic tick();
    logic [14:0] act, exp;
    @(negedge clk);
    act = {acc, flag_n, flag_v, flag_z, flag_c, done, op_ready};
    exp = {8'(m_acc), m_n, m_v, m_z, m_c, m_done, (!m_busy && !ld_en)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {acc,N,V,Z,C,done,ready} actual=%h expected=%h", cur_tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] a, input logic [3:0] f, input string tag);
    cur_tag = tag;
    ld_en = 1; ld_acc = a; ld_flags = f;
    tick();
    ld_en = 0;
    tick();
  endtask

  task automatic do_add(input logic [7:0] m, input logic d, input string tag);
    cur_tag = tag;
    op_valid = 1; op_data = m; dec_mode = d;
    tick();
    op_valid = 0;
    tick();
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cur_tag = "R1";
    tick(); tick();
    rst = 0;
    tick();

    // binary cases
    do_load(8'h50, 4'b0000, "R10");
    do_add(8'h50, 0, "R9 R4");
    do_load(8'hFF, 4'b0000, "R10");
    do_add(8'h01, 0, "R4 R5");
    do_add(8'h10, 0, "R12");
    // decimal cases
    do_load(8'h58, 4'b0001, "R10");
    do_add(8'h46, 1, "R8 R12");
    do_load(8'h99, 4'b0000, "R10");
    do_add(8'h01, 1, "R5 R8");
    do_load(8'h79, 4'b0001, "R10");
    do_add(8'h00, 1, "R7 R9");
    do_load(8'h15, 4'b0000, "R10");
    do_add(8'h27, 1, "R6");
    do_load(8'h0F, 4'b0000, "R10");
    do_add(8'h0F, 1, "R11");
    do_load(8'hFA, 4'b0001, "R10");
    do_add(8'hCB, 1, "R11");

    // held valid across busy cycle, and load attempted while busy
    cur_tag = "R2";
    op_valid = 1; op_data = 8'h22; dec_mode = 0;
    tick();
    ld_en = 1; ld_acc = 8'hAA; ld_flags = 4'hF; cur_tag = "R10";
    tick();
    ld_en = 0; cur_tag = "R2";
    tick();
    op_valid = 0;
    tick(); tick();

    // load wins over simultaneous operand
    cur_tag = "R10";
    op_valid = 1; op_data = 8'h33; ld_en = 1; ld_acc = 8'h44; ld_flags = 4'b0010;
    tick();
    op_valid = 0; ld_en = 0;
    tick(); tick();

    // idle holds
    cur_tag = "R3";
    repeat (3) tick();

    for (int i = 0; i < 3000; i++) begin
      if (i % 7 == 0) do_load(8'($urandom), 4'($urandom), "R10");
      do_add(8'($urandom), 1'($urandom), "R4 R6 R7 R8 R9");
    end

    // reset mid-stream
    cur_tag = "R1";
    op_valid = 1; op_data = 8'h12;
    tick();
    rst = 1; op_valid = 0;
    tick(); tick();
    rst = 0;
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule